// File: doc/BRIEF.md
# Address Filter Decision and Interrupt Unit

This unit turns the outcome of station-address lookups into frame-level decisions for a bridge port. A parser and CAM sequencer elsewhere look up the destination and the source address of each received frame. They report each lookup as a one-cycle strobe with a hit flag, and the CAM full flag is also an input. This unit applies a 16-bit control word to those results. From it the unit drives an active-low reject line to the Ethernet controller, issues one-cycle requests to learn an unknown source address or to fetch the associated data of a matching destination entry, and keeps a sticky status byte. It also raises an active-low interrupt when the source-address field ends.

Destination and source filtering each have their own polarity and their own reject enable. In positive filtering, a frame is dropped when its address is missing from the table. In negative filtering, it is dropped when the address is present. When network filtering is switched off, the unit ignores lookup results and holds the reject line at a fixed level chosen by the host. The host side is a small synchronous register port. It gives read/write access to the control word, read-to-clear access to the status byte, and read access to the captured associated data.

Top module: `afd_filter_unit`

## Requirements
- R1: After reset, reject_n and irq_n are high, learn_req and fetch_req are low, the control word reads 4000h (filtering off, pass all), and the status reads 0000h.
- R2: A host write to address 0 loads the control word. Any host read returns data on host_rdata one clock after the request. Address 1 returns the status in bits 7:0 with bits 15:8 zero, address 2 returns the captured associated data, and address 3 returns 0000h. Writes to addresses 1 to 3 leave the control word unchanged.
- R3: While control bit 13 (network enable) is 1, a da_done strobe with control bit 3 set drives reject_n low one clock later if the lookup missed and control bit 5 is 1, or if it hit and bit 5 is 0.
- R4: While enabled, an sa_done strobe applies the same rule, with control bit 4 choosing the polarity and control bit 2 enabling the reject.
- R5: While enabled, a frm_start strobe with no lookup strobe in the same cycle returns reject_n high one clock later.
- R6: While control bit 13 is 0, reject_n equals control bit 14 one clock after any edge, and lookup strobes change neither the status, learn_req nor fetch_req.
- R7: While enabled, an sa_done miss with control bit 1 set and cam_full low pulses learn_req for one clock, one clock later.
- R8: If cam_full is high in that case, no learn request is made and status bit 3 is set instead.
- R9: While enabled, a da_done hit with control bit 0 set pulses fetch_req for one clock, one clock later. The assoc_data value present with assoc_valid is captured and read back at address 2.
- R10: The status byte holds sticky flags set by enabled lookups: bit 4 any hit, bit 2 destination hit, bit 1 source hit, bit 0 frame rejected. It also holds bit 7 for collision and bit 6 for loss of carrier. Bit 5 reports the live net_busy input.
- R11: One clock after an enabled sa_done, irq_n goes low if any enabled cause holds for the frame. The causes are: bit 15 lookups done, bit 11 full, bit 10 destination miss, bit 9 source miss, bit 8 destination hit, bit 7 source hit, and bit 6 frame rejected.
- R12: A col_evt or loc_evt strobe with control bit 12 set drives irq_n low one clock later.
- R13: A status read clears the status and releases irq_n one clock later. A flag or interrupt cause arriving in the same clock as the read survives it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Start-of-frame strobe |
| da_done | input | 1 | Destination lookup complete strobe |
| da_hit | input | 1 | Destination lookup found an entry |
| sa_done | input | 1 | Source lookup complete strobe (end of source field) |
| sa_hit | input | 1 | Source lookup found an entry |
| cam_full | input | 1 | CAM has no free location |
| col_evt | input | 1 | Collision strobe |
| loc_evt | input | 1 | Loss-of-carrier strobe |
| net_busy | input | 1 | Network side currently owns the CAM |
| assoc_valid | input | 1 | Associated data valid strobe |
| assoc_data | input | ASSOC_W | Associated data from the matching entry |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 2 | Host register address |
| host_wdata | input | REG_W | Host write data |
| host_rdata | output | REG_W | Registered host read data |
| reject_n | output | 1 | Active-low frame reject to the controller |
| irq_n | output | 1 | Active-low interrupt |
| learn_req | output | 1 | One-clock request to learn the source address |
| fetch_req | output | 1 | One-clock request to fetch associated data |

## Verification
Every decision output (reject_n, learn_req, fetch_req, irq_n) is due exactly one clock after the strobe that causes it, and host read data is due one clock after the request. The bench drives each strobe for one clock from the falling edge and samples at the next falling edge, so every check lands in the cycle its result is due. A one-clock pulse is checked again at the following falling edge. When filtering is switched off, the new reject level lags the control write by two edges, and the bench waits that extra clock before checking it.

// File: rtl/afd_pkg.sv
package afd_pkg;
  // control word fields (positions are visible to host software)
  localparam int C_DONE  = 15;
  localparam int C_PASS  = 14;
  localparam int C_NETEN = 13;
  localparam int C_ERR   = 12;
  localparam int C_FULL  = 11;
  localparam int C_NODA  = 10;
  localparam int C_NOSA  = 9;
  localparam int C_DAM   = 8;
  localparam int C_SAM   = 7;
  localparam int C_REJ   = 6;
  localparam int C_DAPOS = 5;
  localparam int C_SAPOS = 4;
  localparam int C_DAREJ = 3;
  localparam int C_SAREJ = 2;
  localparam int C_LEARN = 1;
  localparam int C_ASSOC = 0;
  localparam int CTRL_W  = 16;

  // status byte fields
  localparam int S_COL  = 7;
  localparam int S_LOC  = 6;
  localparam int S_BUSY = 5;
  localparam int S_ANY  = 4;
  localparam int S_FULL = 3;
  localparam int S_DA   = 2;
  localparam int S_SA   = 1;
  localparam int S_REJ  = 0;
  localparam int STAT_W = 8;

  localparam int HOST_AW = 2;
  typedef enum logic [HOST_AW-1:0] {
    RA_CTRL  = 2'd0,
    RA_STAT  = 2'd1,
    RA_ASSOC = 2'd2,
    RA_SPARE = 2'd3
  } reg_addr_e;

  // true when the lookup outcome calls for dropping the frame
  function automatic logic drop_on(input logic hit, input logic positive);
    return positive ? !hit : hit;
  endfunction
endpackage

// File: rtl/afd_host_regs.sv
module afd_host_regs
  import afd_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int ASSOC_W = 16,
  parameter logic [REG_W-1:0] CTRL_RST = 16'h4000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [REG_W-1:0]   host_wdata,
  input  logic [STAT_W-1:0]  status,
  input  logic               assoc_valid,
  input  logic [ASSOC_W-1:0] assoc_data,
  output logic [REG_W-1:0]   ctrl_q,
  output logic [REG_W-1:0]   rdata_q,
  output logic               stat_rd
);
  reg_addr_e          sel;
  logic [ASSOC_W-1:0] assoc_q;
  logic [REG_W-1:0]   rd_mux;
  logic               ctrl_wr;

  assign sel     = reg_addr_e'(host_addr);
  assign ctrl_wr = host_req && host_we && (sel == RA_CTRL);
  assign stat_rd = host_req && !host_we && (sel == RA_STAT);

  always_comb begin
    case (sel)
      RA_CTRL:  rd_mux = ctrl_q;
      RA_STAT:  rd_mux = REG_W'(status);
      RA_ASSOC: rd_mux = REG_W'(assoc_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RST;
      assoc_q <= '0;
      rdata_q <= '0;
    end else begin
      if (ctrl_wr)                ctrl_q  <= host_wdata;
      if (assoc_valid)            assoc_q <= assoc_data;
      if (host_req && !host_we)   rdata_q <= rd_mux;
    end
  end

  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_we && host_addr == 2'd0) |=> (ctrl_q == $past(host_wdata)));

  p_status_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (rdata_q[REG_W-1:STAT_W] == '0));
endmodule

// File: rtl/afd_decide.sv
module afd_decide
  import afd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              frm_start,
  input  logic              da_done,
  input  logic              da_hit,
  input  logic              sa_done,
  input  logic              sa_hit,
  input  logic              cam_full,
  output logic              rej_q,
  output logic              learn_q,
  output logic              fetch_q,
  output logic              da_rej_evt,
  output logic              sa_rej_evt,
  output logic              full_evt
);
  logic net_en;
  logic learn_want;
  logic fetch_want;
  logic unused_ctrl_bits;

  assign net_en     = ctrl[C_NETEN];
  assign da_rej_evt = net_en && da_done && ctrl[C_DAREJ] && drop_on(da_hit, ctrl[C_DAPOS]);
  assign sa_rej_evt = net_en && sa_done && ctrl[C_SAREJ] && drop_on(sa_hit, ctrl[C_SAPOS]);
  assign learn_want = net_en && sa_done && !sa_hit && ctrl[C_LEARN];
  assign full_evt   = learn_want && cam_full;
  assign fetch_want = net_en && da_done && da_hit && ctrl[C_ASSOC];
  assign unused_ctrl_bits = ^ctrl[C_DONE:C_REJ];

  always_ff @(posedge clk) begin
    if (rst) begin
      rej_q   <= 1'b0;
      learn_q <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      learn_q <= learn_want && !cam_full;
      fetch_q <= fetch_want;
      if (!net_en)                       rej_q <= !ctrl[C_PASS];
      else if (da_rej_evt || sa_rej_evt) rej_q <= 1'b1;
      else if (frm_start)                rej_q <= 1'b0;
    end
  end

  p_learn_needs_room_r8: assert property (@(posedge clk) disable iff (rst)
    learn_q |-> $past(!cam_full && sa_done && !sa_hit));

  p_release_at_start_r5: assert property (@(posedge clk) disable iff (rst)
    (net_en && frm_start && !da_done && !sa_done) |=> !rej_q);
endmodule

// File: rtl/afd_irq_status.sv
module afd_irq_status
  import afd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              frm_start,
  input  logic              da_done,
  input  logic              da_hit,
  input  logic              sa_done,
  input  logic              sa_hit,
  input  logic              da_rej_evt,
  input  logic              sa_rej_evt,
  input  logic              full_evt,
  input  logic              col_evt,
  input  logic              loc_evt,
  input  logic              net_busy,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] status,
  output logic              irq_q
);
  logic              net_en, da_ev, sa_ev;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] sticky_q;
  logic              fr_dahit, fr_damiss, fr_rej;
  logic              frame_rej, end_cause, err_cause;
  logic              unused_ctrl_bits;

  assign net_en = ctrl[C_NETEN];
  assign da_ev  = net_en && da_done;
  assign sa_ev  = net_en && sa_done;
  assign unused_ctrl_bits = ^{ctrl[C_PASS], ctrl[C_DAPOS:C_ASSOC]};

  always_comb begin
    set_vec         = '0;
    set_vec[S_COL]  = col_evt;
    set_vec[S_LOC]  = loc_evt;
    set_vec[S_ANY]  = (da_ev && da_hit) || (sa_ev && sa_hit);
    set_vec[S_FULL] = full_evt;
    set_vec[S_DA]   = da_ev && da_hit;
    set_vec[S_SA]   = sa_ev && sa_hit;
    set_vec[S_REJ]  = da_rej_evt || sa_rej_evt;
  end

  // one sticky flag per status bit; the busy bit is live, not stored
  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    if (i == S_BUSY) begin : g_live
      assign sticky_q[i] = 1'b0;
    end else begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst) sticky_q[i] <= 1'b0;
        else     sticky_q[i] <= (stat_rd ? 1'b0 : sticky_q[i]) | set_vec[i];
      end
    end
  end

  always_comb begin
    status         = sticky_q;
    status[S_BUSY] = net_busy;
  end

  // per-frame memory of the destination outcome for the end-of-frame causes
  always_ff @(posedge clk) begin
    if (rst) begin
      fr_dahit  <= 1'b0;
      fr_damiss <= 1'b0;
      fr_rej    <= 1'b0;
    end else if (frm_start) begin
      fr_dahit  <= 1'b0;
      fr_damiss <= 1'b0;
      fr_rej    <= 1'b0;
    end else begin
      if (da_ev)      fr_dahit  <= da_hit;
      if (da_ev)      fr_damiss <= !da_hit;
      if (da_rej_evt) fr_rej    <= 1'b1;
    end
  end

  assign frame_rej = fr_rej || da_rej_evt || sa_rej_evt;
  assign end_cause = sa_ev && (ctrl[C_DONE]
                   || (ctrl[C_FULL] && full_evt)
                   || (ctrl[C_NODA] && fr_damiss)
                   || (ctrl[C_NOSA] && !sa_hit)
                   || (ctrl[C_DAM]  && fr_dahit)
                   || (ctrl[C_SAM]  && sa_hit)
                   || (ctrl[C_REJ]  && frame_rej));
  assign err_cause = ctrl[C_ERR] && (col_evt || loc_evt);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (stat_rd ? 1'b0 : irq_q) | end_cause | err_cause;
  end

  p_read_clears_r13: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !da_done && !sa_done && !col_evt && !loc_evt) |=> (sticky_q == '0 && !irq_q));

  p_error_irq_r12: assert property (@(posedge clk) disable iff (rst)
    (ctrl[C_ERR] && (col_evt || loc_evt)) |=> irq_q);
endmodule

// File: rtl/afd_filter_unit.sv
module afd_filter_unit
  import afd_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int ASSOC_W = 16,
  parameter logic [REG_W-1:0] CTRL_RST = 16'h4000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_start,
  input  logic               da_done,
  input  logic               da_hit,
  input  logic               sa_done,
  input  logic               sa_hit,
  input  logic               cam_full,
  input  logic               col_evt,
  input  logic               loc_evt,
  input  logic               net_busy,
  input  logic               assoc_valid,
  input  logic [ASSOC_W-1:0] assoc_data,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [1:0]         host_addr,
  input  logic [REG_W-1:0]   host_wdata,
  output logic [REG_W-1:0]   host_rdata,
  output logic               reject_n,
  output logic               irq_n,
  output logic               learn_req,
  output logic               fetch_req
);
  logic [REG_W-1:0]  ctrl_q;
  logic [CTRL_W-1:0] ctrl;
  logic [STAT_W-1:0] status;
  logic              stat_rd;
  logic              rej_q, irq_q;
  logic              da_rej_evt, sa_rej_evt, full_evt;

  assign ctrl = ctrl_q[CTRL_W-1:0];

  afd_host_regs #(.REG_W(REG_W), .ASSOC_W(ASSOC_W), .CTRL_RST(CTRL_RST)) u_regs (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .status(status),
    .assoc_valid(assoc_valid), .assoc_data(assoc_data),
    .ctrl_q(ctrl_q), .rdata_q(host_rdata), .stat_rd(stat_rd)
  );

  afd_decide u_decide (
    .clk(clk), .rst(rst), .ctrl(ctrl), .frm_start(frm_start),
    .da_done(da_done), .da_hit(da_hit), .sa_done(sa_done), .sa_hit(sa_hit),
    .cam_full(cam_full), .rej_q(rej_q), .learn_q(learn_req), .fetch_q(fetch_req),
    .da_rej_evt(da_rej_evt), .sa_rej_evt(sa_rej_evt), .full_evt(full_evt)
  );

  afd_irq_status u_irq (
    .clk(clk), .rst(rst), .ctrl(ctrl), .frm_start(frm_start),
    .da_done(da_done), .da_hit(da_hit), .sa_done(sa_done), .sa_hit(sa_hit),
    .da_rej_evt(da_rej_evt), .sa_rej_evt(sa_rej_evt), .full_evt(full_evt),
    .col_evt(col_evt), .loc_evt(loc_evt), .net_busy(net_busy),
    .stat_rd(stat_rd), .status(status), .irq_q(irq_q)
  );

  assign reject_n = !rej_q;
  assign irq_n    = !irq_q;

  p_disabled_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !ctrl[C_NETEN] |=> (reject_n == $past(ctrl[C_PASS])));

  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (rst)
    !ctrl[C_NETEN] |=> (!learn_req && !fetch_req));
endmodule

// File: tb/afd_filter_unit_bench.sv
`timescale 1ns/1ps
module afd_filter_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_start = 0, da_done = 0, da_hit = 0, sa_done = 0, sa_hit = 0;
  logic        cam_full = 0, col_evt = 0, loc_evt = 0, net_busy = 0;
  logic        assoc_valid = 0;
  logic [15:0] assoc_data = '0;
  logic        host_req = 0, host_we = 0;
  logic [1:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        reject_n, irq_n, learn_req, fetch_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  afd_filter_unit u_afd_filter_unit (
    .clk(clk), .rst(rst), .frm_start(frm_start), .da_done(da_done), .da_hit(da_hit),
    .sa_done(sa_done), .sa_hit(sa_hit), .cam_full(cam_full), .col_evt(col_evt),
    .loc_evt(loc_evt), .net_busy(net_busy), .assoc_valid(assoc_valid),
    .assoc_data(assoc_data), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reject_n(reject_n), .irq_n(irq_n), .learn_req(learn_req), .fetch_req(fetch_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [15:0] d);
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    tick();
    host_req = 0; host_we = 0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [15:0] d);
    host_req = 1; host_we = 0; host_addr = a;
    tick();
    host_req = 0;
    d = host_rdata;
  endtask

  function automatic bit drops(input bit hit, input bit pos);
    return pos ? !hit : hit;
  endfunction

  function automatic bit exp_irq(input logic [15:0] c, input bit dah, input bit sah,
                                 input bit fullev, input bit rej);
    return c[13] && (c[15] || (c[11] && fullev) || (c[10] && !dah) || (c[9] && !sah)
                     || (c[8] && dah) || (c[7] && sah) || (c[6] && rej));
  endfunction

  // one whole frame: control write, status clear, start, DA lookup, SA lookup, status read
  task automatic run_frame(input logic [15:0] c, input bit dah, input bit sah, input bit full);
    logic [15:0] rd;
    bit en, rej1, rej2, fullev;
    logic [7:0] st;
    en = c[13];
    hwrite(2'd0, c);
    tick();
    hread(2'd1, rd);
    if (en) begin
      frm_start = 1; tick(); frm_start = 0;
      chk("R5 reject released at frame start", reject_n, 1);
    end else begin
      chk("R6 reject held by pass bit", reject_n, c[14]);
    end
    cam_full = full;
    rej1 = en && c[3] && drops(dah, c[5]);
    da_done = 1; da_hit = dah; tick(); da_done = 0;
    chk(en ? "R3 reject after DA" : "R6 reject after DA", reject_n, en ? !rej1 : c[14]);
    chk(en ? "R9 fetch request" : "R6 no fetch", fetch_req, en && dah && c[0]);
    rej2   = rej1 || (en && c[2] && drops(sah, c[4]));
    fullev = en && !sah && c[1] && full;
    sa_done = 1; sa_hit = sah; tick(); sa_done = 0;
    chk(en ? "R4 reject after SA" : "R6 reject after SA", reject_n, en ? !rej2 : c[14]);
    chk(en ? "R7 learn request" : "R6 no learn", learn_req, en && !sah && c[1] && !full);
    chk("R11 end-of-frame interrupt", irq_n, !exp_irq(c, dah, sah, fullev, rej2));
    cam_full = 0;
    st = '0;
    if (en) st = {3'b000, dah | sah, fullev, dah, sah, rej2};
    hread(2'd1, rd);
    chk(en ? "R10 status after frame" : "R6 status untouched", rd, {8'h00, st});
    tick();
    chk("R13 irq released by status read", irq_n, 1);
  endtask

  initial begin
    logic [15:0] rd;
    logic [15:0] c;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst = 0;
    tick();

    // R1 reset state
    chk("R1 reject_n", reject_n, 1);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 learn/fetch", {learn_req, fetch_req}, 0);
    hread(2'd0, rd); chk("R1 control default", rd, 16'h4000);
    hread(2'd1, rd); chk("R1 status default", rd, 16'h0000);

    // R2 register access
    hwrite(2'd0, 16'h2109);
    hread(2'd0, rd); chk("R2 control readback", rd, 16'h2109);
    hwrite(2'd1, 16'hFFFF); hwrite(2'd3, 16'hFFFF);
    hread(2'd0, rd); chk("R2 control unchanged by other writes", rd, 16'h2109);
    hread(2'd3, rd); chk("R2 spare address reads zero", rd, 16'h0000);

    // R9 associated data capture and a 2109h frame (negative DA filter, DA-hit irq)
    run_frame(16'h2109, 1, 1, 0);
    assoc_valid = 1; assoc_data = 16'hBEEF; tick(); assoc_valid = 0;
    hread(2'd2, rd); chk("R9 associated data readback", rd, 16'hBEEF);

    // R3 positive DA filter, R4 positive SA filter
    run_frame(16'h2028, 0, 1, 0);
    run_frame(16'h2014, 1, 0, 0);

    // R8 full blocks learning and raises full interrupt
    run_frame(16'h2802, 1, 0, 1);

    // R6 disabled, reject-all with learn enabled: strobes ignored
    run_frame(16'h0003, 1, 0, 0);
    hwrite(2'd0, 16'h4000); tick();
    chk("R6 pass-all level", reject_n, 1);

    // R12 error interrupts and R10 error flags
    hwrite(2'd0, 16'h3000);
    col_evt = 1; tick(); col_evt = 0;
    chk("R12 collision irq", irq_n, 0);
    hread(2'd1, rd); chk("R10 collision flag", rd, 16'h0080);
    tick(); chk("R13 irq cleared", irq_n, 1);
    loc_evt = 1; tick(); loc_evt = 0;
    chk("R12 carrier-loss irq", irq_n, 0);
    hread(2'd1, rd); chk("R10 carrier-loss flag", rd, 16'h0040);

    // R10 live busy bit
    net_busy = 1; tick();
    hread(2'd1, rd); chk("R10 busy bit live", rd, 16'h0020);
    net_busy = 0; tick();
    hread(2'd1, rd); chk("R10 busy bit not sticky", rd, 16'h0000);

    // R13 set in the same clock as the clearing read survives
    host_req = 1; host_we = 0; host_addr = 2'd1; col_evt = 1;
    tick();
    host_req = 0; col_evt = 0;
    chk("R13 read returns pre-set value", host_rdata, 16'h0000);
    chk("R13 irq from same-cycle cause", irq_n, 0);
    hread(2'd1, rd); chk("R13 flag survives same-cycle read", rd, 16'h0080);

    // constrained random frames
    for (int i = 0; i < 150; i++) begin
      c = 16'($urandom());
      c[12] = 1'b0;
      c[13] = (($urandom() % 4) != 0);
      run_frame(c, 1'($urandom()), 1'($urandom()), (($urandom() % 3) == 0));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule